// File: doc/BRIEF.md
# Lane-Split Predicated ALU Execute Unit

This unit carries out one register-direct arithmetic or logic instruction per clock. It splits the 32-bit instruction word into its fields and fetches up to three operands through three register-file read ports: a predicate register, a first source and a register second source. It then computes the result as four 8-bit lanes, two 16-bit lanes or one 32-bit lane, rotates the result left, and produces a registered write to the destination register. The write appears one cycle after the instruction is presented.

An instruction takes effect only when its predicate register holds a nonzero value. The two comparison opcodes never write a register. They update a held status word instead. A write to register 15 is also reported as a taken jump. A memory-class word and the reserved granularity code are flagged as illegal and change nothing. The second operand comes from a register, from a sign-extended 4-bit constant, or from a sign-extended 13-bit constant. A constant is applied to every lane alike.

Top module: `simd_cond_alu`

## Requirements
- R1: When instruction bit 31 is 1 (memory class), `bad_op` is 1 in the following cycle, `wr_en` and `jump_taken` stay 0, and `stat_val` is unchanged.
- R2: Operation field bits 30:28 select the operation. Code 0 is OR, 1 is XOR, 2 is AND and 3 is MOV. MOV copies the second operand. Code 4 is ADD, 5 is SUB, 6 is TST and 7 is CMP.
- R3: Granularity bits 15:14 select the lane width: 0 gives four 8-bit lanes, 1 gives two 16-bit lanes and 2 gives one 32-bit lane. ADD and SUB are computed modulo the lane width, and no carry or borrow crosses between lanes.
- R4: Granularity code 3 gives `bad_op` = 1 in the following cycle, with no write, no jump and no status update.
- R5: When bit 13 is 0, the result is rotated left by bits 12:8 (0..31) before it is written. When bit 13 is 1, no rotation is applied.
- R6: When bit 13 is 1, the second operand is bits 12:0 sign-extended. When bit 13 is 0 and bit 4 is 1, it is bits 3:0 sign-extended. When bits 13 and 4 are both 0, it is register bits 3:0. A constant's low lane-width bits are used in every lane.
- R7: The predicate register is named by bits 23:20. When its value is zero, there is no write, no jump and no status update.
- R8: The destination is named by bits 27:24, and the first source by bits 19:16. The three read-index outputs follow the instruction combinationally.
- R9: A write to register 15 raises `jump_taken` in the same cycle as `wr_en`. `jump_taken` is never high without such a write.
- R10: TST (AND) and CMP (SUB, lane-split) never write a register. When they execute, `stat_val` takes their unrotated result. All other instructions leave `stat_val` unchanged.
- R11: All outputs are registered and show the instruction presented in the previous cycle. Reset clears `wr_en`, `wr_idx`, `wr_data`, `bad_op`, `jump_taken` and `stat_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word, one per cycle |
| rd_cond_idx | output | 4 | Read index of the predicate register |
| rd_cond_data | input | 32 | Predicate register value |
| rd_a_idx | output | 4 | Read index of the first source |
| rd_a_data | input | 32 | First source value |
| rd_b_idx | output | 4 | Read index of the register second source |
| rd_b_data | input | 32 | Register second source value |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Rotated result |
| bad_op | output | 1 | Illegal encoding seen |
| jump_taken | output | 1 | Write to register 15 |
| stat_val | output | 32 | Last TST/CMP result, held |

## Verification
Directed operand pairs that overflow every byte, such as 0x00FF00FF plus 1 and 0 minus 1, are run at each of the three lane widths. They separate correct carry isolation from carries that leak across a lane boundary or that are cut in the wrong place. Small and long constants at their extremes (-8, 7, -4096, 4095) show whether sign extension and per-lane replication are correct. Rotation by 1, 16 and 31 fixes the direction and the wrap of the rotate. Randomised instruction words over a register file that holds zero and nonzero predicates then mix all opcodes, formats, illegal encodings and jumps.

// File: rtl/salu_pkg.sv
package salu_pkg;

   localparam int INSTR_W   = 32;
   localparam int REG_IDX_W = 4;
   localparam int ROT_W     = 5;
   localparam int LIMM_W    = 13;
   localparam int SIMM_W    = 4;
   localparam int GRAN_W    = 2;

   // field positions inside the instruction word
   localparam int F_CLASS   = 31;
   localparam int F_OP_LO   = 28;
   localparam int F_DST_LO  = 24;
   localparam int F_COND_LO = 20;
   localparam int F_SRC1_LO = 16;
   localparam int F_GRAN_LO = 14;
   localparam int F_LONG    = 13;
   localparam int F_ROT_LO  = 8;
   localparam int F_SPARE_LO = 5;
   localparam int F_IMMSEL  = 4;
   localparam int F_SRC2_LO = 0;

   typedef enum logic [2:0] {
      OP_OR  = 3'd0,
      OP_XOR = 3'd1,
      OP_AND = 3'd2,
      OP_MOV = 3'd3,
      OP_ADD = 3'd4,
      OP_SUB = 3'd5,
      OP_TST = 3'd6,
      OP_CMP = 3'd7
   } op_e;

   typedef enum logic [GRAN_W-1:0] {
      G_B8  = 2'd0,
      G_H16 = 2'd1,
      G_W32 = 2'd2,
      G_BAD = 2'd3
   } gran_e;

   typedef struct packed {
      logic                 illegal;
      op_e                  op;
      logic [REG_IDX_W-1:0] dst;
      logic [REG_IDX_W-1:0] cond;
      logic [REG_IDX_W-1:0] src1;
      logic [REG_IDX_W-1:0] src2;
      gran_e                gran;
      logic                 use_imm;
      logic [ROT_W-1:0]     rot;
      logic                 writes;
   } dec_t;

endpackage

// File: rtl/salu_decode.sv
module salu_decode
   import salu_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec,
   output logic [DATA_W-1:0]  imm
);

   if (DATA_W < LIMM_W) begin : g_chk_w
      $error("salu_decode: DATA_W must hold the long constant");
   end

   logic long_c;
   logic unused_spare;

   assign long_c       = instr[F_LONG];
   assign unused_spare = ^instr[F_IMMSEL-1:F_SPARE_LO];

   always_comb begin
      dec.op      = op_e'(instr[F_OP_LO +: 3]);
      dec.dst     = instr[F_DST_LO  +: REG_IDX_W];
      dec.cond    = instr[F_COND_LO +: REG_IDX_W];
      dec.src1    = instr[F_SRC1_LO +: REG_IDX_W];
      dec.src2    = instr[F_SRC2_LO +: REG_IDX_W];
      dec.gran    = gran_e'(instr[F_GRAN_LO +: GRAN_W]);
      dec.use_imm = long_c | instr[F_IMMSEL];
      dec.rot     = long_c ? '0 : instr[F_ROT_LO +: ROT_W];
      dec.illegal = instr[F_CLASS] | (dec.gran == G_BAD);
      dec.writes  = !((dec.op == OP_TST) || (dec.op == OP_CMP));
   end

   always_comb begin
      if (long_c)
         imm = {{(DATA_W-LIMM_W){instr[LIMM_W-1]}}, instr[LIMM_W-1:0]};
      else
         imm = {{(DATA_W-SIMM_W){instr[F_SRC2_LO+SIMM_W-1]}},
                instr[F_SRC2_LO +: SIMM_W]};
   end

endmodule

// File: rtl/salu_lane_core.sv
module salu_lane_core
   import salu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SLICE_W = 8
)(
   input  op_e               op,
   input  gran_e             gran,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb_reg,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] res
);

   localparam int NSLICE = DATA_W / SLICE_W;

   if (NSLICE * SLICE_W != DATA_W || NSLICE != 4) begin : g_chk_slices
      $error("salu_lane_core: DATA_W must be four slices of SLICE_W");
   end

   logic is_sub;
   assign is_sub = (op == OP_SUB) || (op == OP_CMP);

   for (genvar k = 0; k < NSLICE; k++) begin : g_sl
      localparam int POS_H = k % 2;
      logic [SLICE_W-1:0] a_s, b_s, imm_s, sum_s, r_s;
      logic               lane_start, cin, cout;

      assign a_s = opa[k*SLICE_W +: SLICE_W];

      // constant: the low lane-width bits repeat in every lane
      always_comb begin
         unique case (gran)
            G_B8:    imm_s = imm[0 +: SLICE_W];
            G_H16:   imm_s = imm[POS_H*SLICE_W +: SLICE_W];
            default: imm_s = imm[k*SLICE_W +: SLICE_W];
         endcase
      end

      assign b_s = use_imm ? imm_s : opb_reg[k*SLICE_W +: SLICE_W];

      if (k == 0) begin : g_first
         assign lane_start = 1'b1;
         assign cin        = is_sub;
      end else begin : g_next
         assign lane_start = (gran == G_B8) || ((gran == G_H16) && (POS_H == 0));
         assign cin        = lane_start ? is_sub : g_sl[k-1].cout;
      end

      assign {cout, sum_s} = {1'b0, a_s} + {1'b0, b_s ^ {SLICE_W{is_sub}}}
                             + {{SLICE_W{1'b0}}, cin};

      always_comb begin
         unique case (op)
            OP_OR:          r_s = a_s | b_s;
            OP_XOR:         r_s = a_s ^ b_s;
            OP_AND, OP_TST: r_s = a_s & b_s;
            OP_MOV:         r_s = b_s;
            default:        r_s = sum_s;
         endcase
      end

      assign res[k*SLICE_W +: SLICE_W] = r_s;
   end

endmodule

// File: rtl/salu_rotl.sv
module salu_rotl #(
   parameter int W    = 32,
   parameter int SH_W = 5
)(
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);

   if ((1 << SH_W) != W) begin : g_chk_rot
      $error("salu_rotl: W must equal 2**SH_W");
   end

   logic [SH_W:0][W-1:0] st;
   assign st[0] = din;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int D = 1 << s;
      assign st[s+1] = amt[s] ? {st[s][W-1-D:0], st[s][W-1:W-D]} : st[s];
   end

   assign dout = st[SH_W];

endmodule

// File: rtl/simd_cond_alu.sv
module simd_cond_alu
   import salu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SLICE_W  = 8,
   parameter int JUMP_REG = 15
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [INSTR_W-1:0]   instr,
   output logic [REG_IDX_W-1:0] rd_cond_idx,
   input  logic [DATA_W-1:0]    rd_cond_data,
   output logic [REG_IDX_W-1:0] rd_a_idx,
   input  logic [DATA_W-1:0]    rd_a_data,
   output logic [REG_IDX_W-1:0] rd_b_idx,
   input  logic [DATA_W-1:0]    rd_b_data,
   output logic                 wr_en,
   output logic [REG_IDX_W-1:0] wr_idx,
   output logic [DATA_W-1:0]    wr_data,
   output logic                 bad_op,
   output logic                 jump_taken,
   output logic [DATA_W-1:0]    stat_val
);

   if (JUMP_REG >= (1 << REG_IDX_W)) begin : g_chk_jump
      $error("simd_cond_alu: JUMP_REG out of register range");
   end
   if ($clog2(DATA_W) != ROT_W) begin : g_chk_rotw
      $error("simd_cond_alu: rotate field does not span DATA_W");
   end

   dec_t              dec;
   logic [DATA_W-1:0] imm, core_res, rot_res;
   logic              go, do_wr;

   salu_decode #(.DATA_W(DATA_W)) u_dec (
      .instr (instr),
      .dec   (dec),
      .imm   (imm)
   );

   assign rd_cond_idx = dec.cond;
   assign rd_a_idx    = dec.src1;
   assign rd_b_idx    = dec.src2;

   salu_lane_core #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_core (
      .op      (dec.op),
      .gran    (dec.gran),
      .use_imm (dec.use_imm),
      .opa     (rd_a_data),
      .opb_reg (rd_b_data),
      .imm     (imm),
      .res     (core_res)
   );

   salu_rotl #(.W(DATA_W), .SH_W(ROT_W)) u_rot (
      .din  (core_res),
      .amt  (dec.rot),
      .dout (rot_res)
   );

   assign go    = !dec.illegal && (rd_cond_data != '0);
   assign do_wr = go && dec.writes;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en      <= 1'b0;
         wr_idx     <= '0;
         wr_data    <= '0;
         bad_op     <= 1'b0;
         jump_taken <= 1'b0;
         stat_val   <= '0;
      end else begin
         wr_en      <= do_wr;
         wr_idx     <= dec.dst;
         wr_data    <= rot_res;
         bad_op     <= dec.illegal;
         jump_taken <= do_wr && (dec.dst == REG_IDX_W'(JUMP_REG));
         if (go && !dec.writes)
            stat_val <= core_res;
      end
   end

endmodule

// File: rtl/simd_cond_alu_chk.sv
module simd_cond_alu_chk #(
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       instr,
   input logic [DATA_W-1:0] rd_cond_data,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              bad_op,
   input logic              jump_taken,
   input logic [DATA_W-1:0] stat_val
);

   logic is_cmp_class;
   logic plain_mov;
   assign is_cmp_class = instr[30] && instr[29];
   assign plain_mov = !instr[31] && (instr[30:28] == 3'd3) && (instr[15:14] != 2'd3)
                      && !instr[13] && !instr[4] && (instr[12:8] == 5'd0)
                      && (rd_cond_data != '0);

   assert_class_illegal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      instr[31] |=> (bad_op && !wr_en && !jump_taken));

   assert_mov_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
      plain_mov |=> (wr_en && wr_data == $past(rd_b_data)));

   assert_gran_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr[31] && instr[15:14] == 2'd3) |=> (bad_op && !wr_en));

   assert_pred_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cond_data == '0) |=> (!wr_en && $stable(stat_val)));

   assert_dest_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx == $past(instr[27:24])));

   assert_jump_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      jump_taken |-> (wr_en && wr_idx == 4'd15));

   assert_cmp_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmp_class |=> !wr_en);

   assert_stat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !is_cmp_class |=> $stable(stat_val));

   assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |-> !wr_en);

endmodule

bind simd_cond_alu simd_cond_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/simd_cond_alu_bench.sv
module simd_cond_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic [3:0]  rd_cond_idx, rd_a_idx, rd_b_idx;
   logic [31:0] rd_cond_data, rd_a_data, rd_b_data;
   logic        wr_en, bad_op, jump_taken;
   logic [3:0]  wr_idx;
   logic [31:0] wr_data, stat_val;

   logic [31:0] rf [16];

   always #4 clk = ~clk;   // 125 MHz

   assign rd_cond_data = rf[rd_cond_idx];
   assign rd_a_data    = rf[rd_a_idx];
   assign rd_b_data    = rf[rd_b_idx];

   simd_cond_alu u_simd_cond_alu (
      .clk(clk), .rst_n(rst_n), .instr(instr),
      .rd_cond_idx(rd_cond_idx), .rd_cond_data(rd_cond_data),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .bad_op(bad_op), .jump_taken(jump_taken), .stat_val(stat_val)
   );

   typedef struct {
      logic        en;
      logic [3:0]  idx;
      logic [31:0] data;
      logic        bad;
      logic        jmp;
      logic [31:0] stat;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [31:0] stat_model = '0;
   int          total = 0;
   int          bad = 0;
   int          cyc = 0;
   bit          done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int op, input int dst, input int cnd,
                                      input int s1, input int g, input int rot,
                                      input int isel, input int s2);
      return {1'b0, 3'(op), 4'(dst), 4'(cnd), 4'(s1), 2'(g), 1'b0, 5'(rot), 3'b000,
              1'(isel), 4'(s2)};
   endfunction

   function automatic logic [31:0] mkl(input int op, input int dst, input int cnd,
                                       input int s1, input int g, input int c13);
      return {1'b0, 3'(op), 4'(dst), 4'(cnd), 4'(s1), 2'(g), 1'b1, 13'(c13)};
   endfunction

   // behavioural reference: lane loop over integers
   function automatic exp_t predict(input logic [31:0] ins);
      exp_t        e;
      int          op, g, w, nl;
      longint      mask, al, bl, r, c, res;
      bit          use_c, legal, go;
      logic [31:0] b, resw;
      logic [63:0] dd;
      op = int'(ins[30:28]);
      g  = int'(ins[15:14]);
      w  = (g == 3) ? 32 : (8 << g);
      nl = 32 / w;
      mask = (64'sd1 << w) - 1;
      use_c = 1'b1;
      if (ins[13])      c = longint'($signed(ins[12:0]));
      else if (ins[4])  c = longint'($signed(ins[3:0]));
      else begin        c = 0; use_c = 1'b0; end
      b = rf[ins[3:0]];
      res = 0;
      for (int l = 0; l < nl; l++) begin
         al = (longint'(rf[ins[19:16]]) >> (l*w)) & mask;
         bl = use_c ? (c & mask) : ((longint'(b) >> (l*w)) & mask);
         case (op)
            0:       r = al | bl;
            1:       r = al ^ bl;
            2, 6:    r = al & bl;
            3:       r = bl;
            4:       r = (al + bl) & mask;
            default: r = (al - bl) & mask;
         endcase
         res = res | (r << (l*w));
      end
      resw  = res[31:0];
      legal = !ins[31] && (g != 3);
      go    = legal && (rf[ins[23:20]] != 0);
      dd    = {resw, resw} << (ins[13] ? 0 : int'(ins[12:8]));
      e.en   = go && (op < 6);
      e.idx  = ins[27:24];
      e.data = dd[63:32];
      e.bad  = !legal;
      e.jmp  = e.en && (ins[27:24] == 4'd15);
      if (go && op >= 6) stat_model = resw;
      e.stat = stat_model;
      if (ins[31])                 e.tag = "R1";
      else if (g == 3)             e.tag = "R4";
      else if (rf[ins[23:20]] == 0) e.tag = "R7";
      else if (op >= 6)            e.tag = "R10";
      else if (op >= 4)            e.tag = "R3 R5 R6 R8";
      else                         e.tag = "R2 R5 R6 R8";
      return e;
   endfunction

   task automatic compare_one();
      exp_t e;
      if (q.size() == 0) return;
      e = q.pop_front();
      chk({e.tag, " wr_en"}, 32'(wr_en), 32'(e.en));
      if (e.en) begin
         chk({e.tag, " wr_idx"}, 32'(wr_idx), 32'(e.idx));
         chk({e.tag, " wr_data"}, wr_data, e.data);
      end
      chk({e.tag, " bad_op R1 R4"}, 32'(bad_op), 32'(e.bad));
      chk({e.tag, " jump R9"}, 32'(jump_taken), 32'(e.jmp));
      chk({e.tag, " stat R10"}, stat_val, e.stat);
   endtask

   task automatic step(input logic [31:0] ins);
      @(negedge clk);
      compare_one();
      if (done) return;
      instr = ins;
      q.push_back(predict(ins));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL watchdog R11 actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rf[0]  = 32'h0000_0000;  rf[1]  = 32'h00FF_00FF;  rf[2]  = 32'h0101_0101;
      rf[3]  = 32'hFFFF_FFFF;  rf[4]  = 32'h8000_7FFF;  rf[5]  = 32'h0000_0000;
      rf[6]  = 32'h1234_5678;  rf[7]  = 32'hA5A5_0F0F;  rf[8]  = 32'h0000_0001;
      rf[9]  = 32'h7F80_FF01;  rf[10] = 32'hDEAD_BEEF;  rf[11] = 32'h0000_FFFF;
      rf[12] = 32'hC3C3_3C3C;  rf[13] = 32'h0F0F_F0F0;  rf[14] = 32'h4000_0002;
      rf[15] = 32'h8000_0000;
      repeat (3) @(negedge clk);
      // R11: reset clears every output
      chk("R11 reset wr_en", 32'(wr_en), 0);
      chk("R11 reset bad_op", 32'(bad_op), 0);
      chk("R11 reset jump", 32'(jump_taken), 0);
      chk("R11 reset stat", stat_val, 0);
      chk("R11 reset wr_data", wr_data, 0);
      rst_n = 1'b1;

      // R2 logic ops and MOV with register operands
      for (int op = 0; op < 4; op++) step(mk(op, 3, 2, 6, 2, 0, 0, 7));
      // R3 carry isolation: 0x00FF00FF + 0x01010101 at each granularity
      for (int g = 0; g < 3; g++) step(mk(4, 4, 2, 1, g, 0, 0, 2));
      // R3 borrow isolation: 0 - 1 at each granularity
      for (int g = 0; g < 3; g++) step(mk(5, 4, 2, 0, g, 0, 0, 8));
      // R5 rotation amounts
      step(mk(3, 6, 2, 0, 2, 1, 0, 15));
      step(mk(3, 6, 2, 0, 2, 16, 0, 6));
      step(mk(3, 6, 2, 0, 2, 31, 0, 8));
      // R6 small and long constants at their ends, in every lane width
      for (int g = 0; g < 3; g++) begin
         step(mk(4, 7, 2, 1, g, 0, 1, 8));     // -8
         step(mk(4, 7, 2, 1, g, 0, 1, 7));     // 7
         step(mkl(4, 7, 2, 4, g, 4096));       // -4096
         step(mkl(4, 7, 2, 4, g, 4095));       // 4095
      end
      // R7 zero predicate registers 0 and 5
      step(mk(0, 3, 0, 6, 2, 0, 0, 7));
      step(mk(4, 15, 5, 6, 2, 0, 0, 7));
      // R1 memory class, R4 reserved granularity
      step(32'h8000_0000 | mk(4, 3, 2, 6, 2, 0, 0, 7));
      step(mk(4, 3, 2, 6, 3, 0, 0, 7));
      // R9 jump through a write to register 15, and R8 link register
      step(mk(3, 15, 2, 0, 2, 0, 0, 10));
      step(mk(3, 14, 2, 0, 2, 0, 0, 10));
      // R10 TST, CMP, then a plain op leaves status held
      step(mk(6, 3, 2, 7, 0, 4, 0, 12));
      step(mk(7, 3, 2, 1, 0, 4, 0, 2));
      step(mk(0, 3, 2, 6, 2, 0, 0, 7));
      step(mk(7, 3, 5, 6, 1, 0, 0, 7));     // suppressed CMP
      // mixed traffic
      for (int n = 0; n < 3000; n++) step($urandom());
      step(mk(0, 3, 0, 0, 0, 0, 0, 0));
      @(negedge clk);
      compare_one();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule